// File: doc/BRIEF.md
# Register Operate Unit

A 16-bit register-to-register operate unit for a small accumulator machine. Each operation takes a source word, a destination word and a 4-bit function code. It returns the word to write back to the destination, together with new overflow and carry indicator values. The source can first be replaced by its one's complement. The add, AND and OR functions each come in three forms: a plain form, a form that adds the incoming carry indicator after the main step, and a form that adds one after the main step. In the AND and OR forms that add something, the logical operations therefore also update the arithmetic indicators.

A caller pulses `start` with the operands, the function code and the current indicators. One clock later the registered result and indicators are valid and `done` is high for one cycle. The outputs keep their values until the next start. The register file that holds the operands belongs to the caller.

Top module: `reg_operate_unit`

## Requirements
- R1: After reset, `result`, `ovf_out`, `carry_out` and `done` are all 0.
- R2: `done` is 1 in the cycle after a cycle in which `start` was 1, and 0 in any other cycle.
- R3: In a cycle after one without `start`, `result`, `ovf_out` and `carry_out` keep their values.
- R4: The operand S is `~src` when `inv_src` is 1 and `src` otherwise. Every function uses S in place of the raw source.
- R5: Add codes: 1 gives S+dst, 2 gives S+dst+carry_in, 3 gives S+dst+1. The result is the low 16 bits of the sum, and `carry_out` is the carry out of bit 15.
- R6: In every form that has an add step (codes 1,2,3,5,6,8,9), `ovf_out` is 1 exactly when the sum, read as two's complement, falls outside -32768..32767.
- R7: AND codes: 4 gives S&dst, 5 gives (S&dst)+carry_in, 6 gives (S&dst)+1. In codes 5 and 6, the carry and overflow come from that addition.
- R8: OR codes: 7 gives S|dst, 8 gives (S|dst)+carry_in, 9 gives (S|dst)+1. In codes 8 and 9, the carry and overflow come from that addition.
- R9: Code 0 copies S to the result. Codes 0, 4 and 7 clear both `carry_out` and `ovf_out`.
- R10: Codes 10..15 are unassigned. With them the result is `dst`, `carry_out` equals `carry_in`, and `ovf_out` equals `ovf_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the present inputs |
| func | input | 4 | Function code |
| inv_src | input | 1 | Use the one's complement of the source |
| src | input | 16 | Source register value |
| dst | input | 16 | Destination register value |
| carry_in | input | 1 | Current carry indicator |
| ovf_in | input | 1 | Current overflow indicator |
| result | output | 16 | Value to write to the destination |
| ovf_out | output | 1 | New overflow indicator |
| carry_out | output | 1 | New carry indicator |
| done | output | 1 | One-cycle pulse when outputs are valid |

## Verification
The bench sweeps every function code with both inversion settings and both carry inputs, over operand pairs that include 0, all-ones, 0x7FFF and 0x8000. The cases it targets are these:
- Adding one to all-ones must wrap to zero with carry set and no overflow. A design that took the carry from bit 14 or the sign would fail here.
- Incrementing 0x7FFF after an AND or OR step must raise overflow. A design that left the indicators alone for the logical forms would miss this.
- An inverted source feeding a plain add must give `dst - src - 1`. A design that applied two's complement instead of one's complement would be off by one.
- The unassigned codes must pass `dst` and both indicators straight through. A design that decoded them as copy or cleared the indicators would fail.

// File: rtl/reg_operate_unit.sv
module reg_operate_unit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       func,
  input  logic             inv_src,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  input  logic             carry_in,
  input  logic             ovf_in,
  output logic [WIDTH-1:0] result,
  output logic             ovf_out,
  output logic             carry_out,
  output logic             done
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] s_op, add_a, add_b, res_n;
  logic [WIDTH:0]   sum;
  logic             add_cin, has_add, legal, ovf_n, cy_n;

  assign s_op = inv_src ? ~src : src;

  always_comb begin
    add_a   = s_op;
    add_b   = '0;
    add_cin = 1'b0;
    has_add = 1'b0;
    legal   = 1'b1;
    unique case (func)
      4'd0: ;
      4'd1: begin add_b = dst; has_add = 1'b1; end
      4'd2: begin add_b = dst; add_cin = carry_in; has_add = 1'b1; end
      4'd3: begin add_b = dst; add_cin = 1'b1; has_add = 1'b1; end
      4'd4: add_a = s_op & dst;
      4'd5: begin add_a = s_op & dst; add_cin = carry_in; has_add = 1'b1; end
      4'd6: begin add_a = s_op & dst; add_cin = 1'b1; has_add = 1'b1; end
      4'd7: add_a = s_op | dst;
      4'd8: begin add_a = s_op | dst; add_cin = carry_in; has_add = 1'b1; end
      4'd9: begin add_a = s_op | dst; add_cin = 1'b1; has_add = 1'b1; end
      default: legal = 1'b0;
    endcase
  end

  assign sum = {1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin};

  always_comb begin
    if (!legal) begin
      res_n = dst;
      cy_n  = carry_in;
      ovf_n = ovf_in;
    end else if (has_add) begin
      res_n = sum[MSB:0];
      cy_n  = sum[WIDTH];
      ovf_n = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);
    end else begin
      res_n = add_a;
      cy_n  = 1'b0;
      ovf_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      ovf_out   <= 1'b0;
      carry_out <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result    <= res_n;
        ovf_out   <= ovf_n;
        carry_out <= cy_n;
      end
    end
  end

  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(ovf_out) && $stable(carry_out)));
  p_plain_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (func == 4'd0 || func == 4'd4 || func == 4'd7)) |=> (!ovf_out && !carry_out));
  p_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && func == 4'd0) |=> (result == ($past(inv_src) ? ~$past(src) : $past(src))));
  p_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && func >= 4'd10) |=>
      (result == $past(dst) && carry_out == $past(carry_in) && ovf_out == $past(ovf_in)));
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && func == 4'd1 && (s_op[MSB] != dst[MSB])) |=> !ovf_out);
endmodule

// File: tb/tb_reg_operate_unit.sv
module tb_reg_operate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  func = '0;
  logic        inv_src = 1'b0;
  logic [15:0] src = '0, dst = '0;
  logic        carry_in = 1'b0, ovf_in = 1'b0;
  logic [15:0] result;
  logic        ovf_out, carry_out, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  reg_operate_unit dut (.*);

  logic [15:0] vals [12] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFE, 16'h7FFF,
                             16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF, 16'h5555,
                             16'hAAAA, 16'h1234};

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] f, input logic iv, input logic [15:0] sv,
                       input logic [15:0] dv, input logic ci, input logic oi,
                       output logic [15:0] r, output logic c, output logic o,
                       output string tag);
    logic [15:0] s, a, b;
    int inc, su, sgn;
    s = iv ? ~sv : sv;
    b = 16'h0; inc = 0;
    case (f)
      4'd1, 4'd2, 4'd3: begin a = s; b = dv; tag = "R5"; end
      4'd4, 4'd5, 4'd6: begin a = s & dv; tag = "R7"; end
      4'd7, 4'd8, 4'd9: begin a = s | dv; tag = "R8"; end
      default: begin a = s; tag = "R9"; end
    endcase
    if (f == 4'd2 || f == 4'd5 || f == 4'd8) inc = int'(ci);
    if (f == 4'd3 || f == 4'd6 || f == 4'd9) inc = 1;
    su  = int'(a) + int'(b) + inc;
    sgn = int'($signed(a)) + int'($signed(b)) + inc;
    if (f >= 4'd10) begin
      r = dv; c = ci; o = oi; tag = "R10";
    end else if (f == 4'd0 || f == 4'd4 || f == 4'd7) begin
      r = a; c = 1'b0; o = 1'b0;
    end else begin
      r = su[15:0]; c = (su > 65535); o = (sgn > 32767) || (sgn < -32768);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result", result, 0);
    chk("R1 flags", {ovf_out, carry_out}, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle done", done, 0);

    for (int f = 0; f < 16; f++)
      for (int iv = 0; iv < 2; iv++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++) begin
              logic [15:0] er; logic ec, eo; string tag;
              func = 4'(f); inv_src = iv[0]; carry_in = ci[0];
              ovf_in = ((i + j) % 2) == 1;
              src = vals[i]; dst = vals[j]; start = 1'b1;
              model(func, inv_src, src, dst, carry_in, ovf_in, er, ec, eo, tag);
              @(negedge clk);
              chk("R2 done", done, 1);
              chk({tag, iv ? " R4" : "", " result"}, result, er);
              chk({tag, " carry"}, carry_out, ec);
              chk({(f >= 10 || f == 0 || f == 4 || f == 7) ? tag : "R6", " ovf"}, ovf_out, eo);
              if ((i + j) % 37 == 0) begin
                logic [15:0] hr; logic hc, ho;
                hr = result; hc = carry_out; ho = ovf_out;
                start = 1'b0; src = ~src; dst = ~dst; carry_in = ~carry_in;
                @(negedge clk);
                chk("R2 no done", done, 0);
                chk("R3 hold", {result, carry_out, ovf_out}, {hr, hc, ho});
              end
            end

    start = 1'b0; func = 4'd3; inv_src = 1'b0; src = 16'hFFFF; dst = 16'h0000;
    start = 1'b1; @(negedge clk);
    chk("R5 wrap", {result, carry_out, ovf_out}, {16'h0000, 1'b1, 1'b0});
    func = 4'd9; src = 16'h7FFF; dst = 16'h0000;
    @(negedge clk);
    chk("R8 inc ovf", {result, carry_out, ovf_out}, {16'h8000, 1'b0, 1'b1});
    func = 4'd1; inv_src = 1'b1; src = 16'h0005; dst = 16'h0010;
    @(negedge clk);
    chk("R4 inv add", result, 16'h000A);
    start = 1'b0;
    @(negedge clk);
    finished = 1'b1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin repeat (150000) @(posedge clk); checks++; failures++;
            $display("FAIL watchdog expired"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule